// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block carries out a multi-register memory transfer for a processor core. A start strobe delivers a 16-bit register mask, a base address, the index of the base register and four mode flags: load or store, upward or downward traversal, step-before or step-after addressing, and base update. The sequencer then issues one 32-bit word request for every set mask bit. Each request is held until the memory returns ready.

Stores take their data from a register-file read port that the block points at the register being sent. Storing register 15, the program counter, sends the instruction address plus 12 instead of the register value. Loaded words return through a register-file write port, one cycle after each word arrives. Loading register 15 also raises a pipeline flush pulse.

When the sequence ends, the block pulses done together with the final base address and an enable for writing it back. A request that asks for the user-mode register bank is refused: the block flags it and makes no transfer.

Top module: `lsm_seq`

## Requirements
- R1: Each set bit of `reg_list_i` (bit i selects register i) produces exactly one word request, and a clear bit produces none.
- R2: With `ascend_i`=1, registers are visited from index 0 up to 15, and successive accesses move by +4 bytes.
- R3: With `ascend_i`=0, registers are visited from index 15 down to 0, and successive accesses move by -4 bytes.
- R4: With `pre_i`=1 the first access is at base±4 (step applied before each access); with `pre_i`=0 it is at base (step applied after). All address arithmetic wraps modulo 2^32.
- R5: A request (`mem_req_o`=1) keeps its address, write enable and data unchanged until a cycle in which `mem_ready_i`=1.
- R6: For a load, the cycle after ready is an internal cycle with `rf_we_o`=1, `rf_widx_o` equal to the visited register and `rf_wdata_o` equal to the word captured with ready; no request is issued in that cycle.
- R7: For a store, `mem_we_o`=1 and `mem_wdata_o` is the register-file read data for the visited register; for register 15 it is `instr_pc_i`+12.
- R8: Loading register 15 raises `flush_o` for exactly the one cycle in which register 15 is written.
- R9: `done_o` is a one-cycle pulse in the cycle after the last transfer completes (after the last store's ready, or after the last load's write cycle), with `wb_addr_o` = base ± 4·(number of set bits).
- R10: At done, `wb_en_o` = `wback_i`, except that it is 0 when a load's mask includes the base register `base_idx_i`.
- R11: An empty mask issues no request and pulses done in the cycle after start, with `wb_addr_o` equal to the base.
- R12: With `user_bank_i`=1 no request is issued, and done pulses in the cycle after start with `unsup_o`=1 and `wb_en_o`=0.
- R13: `start_i` and all operand inputs are ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| reg_list_i | input | 16 | Register mask |
| base_addr_i | input | 32 | Base address |
| base_idx_i | input | 4 | Index of the base register |
| is_load_i | input | 1 | 1 = load, 0 = store |
| ascend_i | input | 1 | 1 = upward traversal, +4 step |
| pre_i | input | 1 | 1 = step before each access |
| wback_i | input | 1 | Base update requested |
| user_bank_i | input | 1 | User-bank transfer requested (unsupported) |
| instr_pc_i | input | 32 | Address of the instruction |
| mem_req_o | output | 1 | Memory request valid |
| mem_addr_o | output | 32 | Word address |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data |
| mem_ready_i | input | 1 | Request accepted / data valid |
| rf_ridx_o | output | 4 | Register-file read index for stores |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_widx_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| flush_o | output | 1 | Pipeline flush pulse |
| done_o | output | 1 | Sequence finished |
| wb_en_o | output | 1 | Write `wb_addr_o` to the base register |
| wb_addr_o | output | 32 | Final base value |
| unsup_o | output | 1 | Request was refused |

## Verification
The assertions assume that the memory side drives `mem_ready_i` only as an answer to a live request. They also assume that `rf_rdata_i` reflects `rf_ridx_o` in the same cycle, and that `start_i` carries no meaning while the block is busy. The bench honours these assumptions. Its responder raises ready only after it has seen `mem_req_o`, and its delay is a fixed 0 to 2 cycles per operation. Its register file is a combinational function of the read index. When it holds `start_i` high with scrambled operands during a run, it does so only to show that those inputs are ignored.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int unsigned LSM_AW    = 32;
    localparam int unsigned LSM_DW    = 32;
    localparam int unsigned LSM_NREG  = 16;
    localparam int unsigned LSM_IDX_W = $clog2(LSM_NREG);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_LWAIT = 2'd2,
        ST_FIN   = 2'd3
    } lsm_state_e;

    typedef struct packed {
        lsm_state_e               state;
        logic [LSM_NREG-1:0]      mask;
        logic [LSM_AW-1:0]        addr;
        logic [LSM_AW-1:0]        pc;
        logic                     is_load;
        logic                     ascend;
        logic                     pre;
        logic                     wback;
        logic                     unsup;
        logic                     base_hit;
        logic [LSM_IDX_W-1:0]     ld_idx;
        logic [LSM_DW-1:0]        ld_data;
    } lsm_ctx_t;
endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] mask_i,
    input  logic         ascend_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o
);
    logic [W-1:0] lo_idx, hi_idx;

    always_comb begin
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) lo_idx = W'(i);
        end
    end

    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (mask_i[i]) hi_idx = W'(i);
        end
    end

    assign valid_o = |mask_i;
    assign idx_o   = ascend_i ? lo_idx : hi_idx;

    always_comb begin
        if (valid_o) begin
            assert_pick_selects_set_R1: assert (mask_i[idx_o]);
        end
    end
endmodule

// File: rtl/lsm_step.sv
module lsm_step #(
    parameter int unsigned AW    = 32,
    parameter int unsigned WORD  = 4
) (
    input  logic [AW-1:0] cur_i,
    input  logic          ascend_i,
    input  logic          pre_i,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] nxt_o
);
    localparam logic [AW-1:0] STEP_UP = AW'(WORD);
    localparam logic [AW-1:0] STEP_DN = ~STEP_UP + AW'(1);

    assign nxt_o = cur_i + (ascend_i ? STEP_UP : STEP_DN);
    assign acc_o = pre_i ? nxt_o : cur_i;
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int unsigned PC_IDX = 15,
    parameter int unsigned PC_ADJ = 12,
    parameter int unsigned WORD   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [LSM_NREG-1:0]  reg_list_i,
    input  logic [LSM_AW-1:0]    base_addr_i,
    input  logic [LSM_IDX_W-1:0] base_idx_i,
    input  logic                 is_load_i,
    input  logic                 ascend_i,
    input  logic                 pre_i,
    input  logic                 wback_i,
    input  logic                 user_bank_i,
    input  logic [LSM_AW-1:0]    instr_pc_i,
    output logic                 mem_req_o,
    output logic [LSM_AW-1:0]    mem_addr_o,
    output logic                 mem_we_o,
    output logic [LSM_DW-1:0]    mem_wdata_o,
    input  logic [LSM_DW-1:0]    mem_rdata_i,
    input  logic                 mem_ready_i,
    output logic [LSM_IDX_W-1:0] rf_ridx_o,
    input  logic [LSM_DW-1:0]    rf_rdata_i,
    output logic                 rf_we_o,
    output logic [LSM_IDX_W-1:0] rf_widx_o,
    output logic [LSM_DW-1:0]    rf_wdata_o,
    output logic                 flush_o,
    output logic                 done_o,
    output logic                 wb_en_o,
    output logic [LSM_AW-1:0]    wb_addr_o,
    output logic                 unsup_o
);
    localparam logic [LSM_IDX_W-1:0] PC_SEL = LSM_IDX_W'(PC_IDX);

    lsm_ctx_t ctx_d, ctx_q;

    logic                 pick_vld;
    logic [LSM_IDX_W-1:0] pick_idx;
    logic [LSM_AW-1:0]    acc_addr, nxt_addr;
    logic [LSM_NREG-1:0]  mask_left;

    lsm_pick #(.N(LSM_NREG)) u_pick (
        .mask_i   (ctx_q.mask),
        .ascend_i (ctx_q.ascend),
        .valid_o  (pick_vld),
        .idx_o    (pick_idx)
    );

    lsm_step #(.AW(LSM_AW), .WORD(WORD)) u_step (
        .cur_i    (ctx_q.addr),
        .ascend_i (ctx_q.ascend),
        .pre_i    (ctx_q.pre),
        .acc_o    (acc_addr),
        .nxt_o    (nxt_addr)
    );

    always_comb begin
        mask_left = ctx_q.mask;
        mask_left[pick_idx] = 1'b0;
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.mask     = reg_list_i;
                    ctx_d.addr     = base_addr_i;
                    ctx_d.pc       = instr_pc_i;
                    ctx_d.is_load  = is_load_i;
                    ctx_d.ascend   = ascend_i;
                    ctx_d.pre      = pre_i;
                    ctx_d.wback    = wback_i;
                    ctx_d.unsup    = user_bank_i;
                    ctx_d.base_hit = reg_list_i[base_idx_i];
                    if (user_bank_i || (reg_list_i == '0)) begin
                        ctx_d.state = ST_FIN;
                    end else begin
                        ctx_d.state = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (mem_ready_i) begin
                    ctx_d.mask = mask_left;
                    ctx_d.addr = nxt_addr;
                    if (ctx_q.is_load) begin
                        ctx_d.ld_idx  = pick_idx;
                        ctx_d.ld_data = mem_rdata_i;
                        ctx_d.state   = ST_LWAIT;
                    end else if (mask_left == '0) begin
                        ctx_d.state = ST_FIN;
                    end
                end
            end
            ST_LWAIT: begin
                ctx_d.state = (ctx_q.mask == '0) ? ST_FIN : ST_XFER;
            end
            ST_FIN: begin
                ctx_d.state = ST_IDLE;
            end
            default: ctx_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req_o   = (ctx_q.state == ST_XFER) && pick_vld;
    assign mem_addr_o  = acc_addr;
    assign mem_we_o    = mem_req_o && !ctx_q.is_load;
    assign rf_ridx_o   = pick_idx;
    assign mem_wdata_o = (pick_idx == PC_SEL) ? (ctx_q.pc + LSM_AW'(PC_ADJ)) : rf_rdata_i;

    assign rf_we_o    = (ctx_q.state == ST_LWAIT);
    assign rf_widx_o  = ctx_q.ld_idx;
    assign rf_wdata_o = ctx_q.ld_data;
    assign flush_o    = rf_we_o && (ctx_q.ld_idx == PC_SEL);

    assign done_o    = (ctx_q.state == ST_FIN);
    assign unsup_o   = done_o && ctx_q.unsup;
    assign wb_addr_o = ctx_q.addr;
    assign wb_en_o   = done_o && ctx_q.wback && !ctx_q.unsup
                       && !(ctx_q.is_load && ctx_q.base_hit);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    assert_load_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ready_i && !mem_we_o |=> rf_we_o && !mem_req_o);

    assert_flush_on_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> rf_we_o && (rf_widx_o == PC_SEL));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_refused_R12: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> done_o && !wb_en_o);

    assert_busy_no_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ready_i && (mask_left != '0) && !ctx_q.is_load |=> mem_req_o);
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reg_list_i = '0;
    logic [31:0] base_addr_i = '0;
    logic [3:0]  base_idx_i = '0;
    logic        is_load_i = 1'b0, ascend_i = 1'b0, pre_i = 1'b0, wback_i = 1'b0, user_bank_i = 1'b0;
    logic [31:0] instr_pc_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o, wb_addr_o;
    logic [3:0]  rf_ridx_o, rf_widx_o;
    logic        rf_we_o, flush_o, done_o, wb_en_o, unsup_o;

    localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata_i = mem_addr_o ^ RD_KEY;
    assign rf_rdata_i  = {16'hBEEF, 12'h0, rf_ridx_o};

    lsm_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
        .base_addr_i(base_addr_i), .base_idx_i(base_idx_i), .is_load_i(is_load_i),
        .ascend_i(ascend_i), .pre_i(pre_i), .wback_i(wback_i), .user_bank_i(user_bank_i),
        .instr_pc_i(instr_pc_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_ready_i(mem_ready_i), .rf_ridx_o(rf_ridx_o), .rf_rdata_i(rf_rdata_i),
        .rf_we_o(rf_we_o), .rf_widx_o(rf_widx_o), .rf_wdata_o(rf_wdata_o),
        .flush_o(flush_o), .done_o(done_o), .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o),
        .unsup_o(unsup_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] list, input logic [31:0] base, input logic [3:0] bidx,
                          input bit ld, input bit asc, input bit pre, input bit wb, input bit usr,
                          input logic [31:0] pc, input int lat, input bit hammer);
        int order[16];
        int n = 0;
        int k = 0;
        int waitc = 0;
        bit pend = 0;
        int pend_idx = 0;
        logic [31:0] pend_data = '0;
        bit done_due;
        bit finished = 0;
        logic [31:0] step;
        logic [31:0] exp_addr, exp_fin;
        bit exp_wb;
        for (int i = 0; i < 16; i++) begin
            int r = asc ? i : 15 - i;
            if (list[r] && !usr) begin
                order[n] = r;
                n++;
            end
        end
        step = asc ? 32'd4 : 32'hFFFF_FFFC;
        exp_fin = base + step * 32'(n);
        exp_wb = wb && !usr && !(ld && list[bidx]);
        done_due = (n == 0);
        reg_list_i = list; base_addr_i = base; base_idx_i = bidx; is_load_i = ld;
        ascend_i = asc; pre_i = pre; wback_i = wb; user_bank_i = usr; instr_pc_i = pc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = hammer;
        if (hammer) begin
            reg_list_i = ~list; base_addr_i = ~base; is_load_i = ~ld; ascend_i = ~asc;
            pre_i = ~pre; user_bank_i = 1'b0; base_idx_i = ~bidx;
        end
        for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
            mem_ready_i = 1'b0;
            if (done_due) chk(done_o == 1'b1, "R9/R11/R12", "done timing", 32'(done_o), 1);
            else chk(done_o == 1'b0, "R9", "early done", 32'(done_o), 0);
            if (done_o) begin
                chk(k == n, "R1", "transfer count", 32'(k), 32'(n));
                chk(wb_addr_o == exp_fin, "R9/R4", "final base", wb_addr_o, exp_fin);
                chk(wb_en_o == exp_wb, "R10", "writeback enable", 32'(wb_en_o), 32'(exp_wb));
                chk(unsup_o == usr, "R12", "refused flag", 32'(unsup_o), 32'(usr));
                start_i = 1'b0;
                finished = 1;
                @(negedge clk);
                chk(done_o == 1'b0, "R9", "done single pulse", 32'(done_o), 0);
                chk(mem_req_o == 1'b0, "R13", "idle after done", 32'(mem_req_o), 0);
            end else begin
                if (pend) begin
                    chk(rf_we_o == 1'b1, "R6", "load write enable", 32'(rf_we_o), 1);
                    chk(rf_widx_o == 4'(pend_idx), "R6", "load write index", 32'(rf_widx_o), 32'(pend_idx));
                    chk(rf_wdata_o == pend_data, "R6", "load write data", rf_wdata_o, pend_data);
                    chk(flush_o == (pend_idx == 15), "R8", "flush", 32'(flush_o), 32'(pend_idx == 15));
                    chk(mem_req_o == 1'b0, "R6", "no request in internal cycle", 32'(mem_req_o), 0);
                    pend = 0;
                    k++;
                    if (k == n) done_due = 1;
                end else begin
                    chk(rf_we_o == 1'b0 && flush_o == 1'b0, "R6/R8", "spurious write",
                        {30'd0, rf_we_o, flush_o}, 0);
                    if (mem_req_o) begin
                        if (k >= n) begin
                            chk(0, "R1", "extra request", 32'(k), 32'(n));
                        end else begin
                            exp_addr = base + step * 32'(k + (pre ? 1 : 0));
                            chk(mem_addr_o == exp_addr, asc ? "R2/R4" : "R3/R4", "address",
                                mem_addr_o, exp_addr);
                            chk(mem_we_o == !ld, "R7", "write enable", 32'(mem_we_o), 32'(!ld));
                            if (!ld) begin
                                logic [31:0] ew;
                                ew = (order[k] == 15) ? pc + 32'd12 : {16'hBEEF, 12'h0, 4'(order[k])};
                                chk(mem_wdata_o == ew, "R7", "store data", mem_wdata_o, ew);
                            end
                            if (waitc == lat) begin
                                mem_ready_i = 1'b1;
                                waitc = 0;
                                if (ld) begin
                                    pend = 1;
                                    pend_idx = order[k];
                                    pend_data = exp_addr ^ RD_KEY;
                                end else begin
                                    k++;
                                    if (k == n) done_due = 1;
                                end
                            end else begin
                                waitc++;
                            end
                        end
                    end
                end
                @(negedge clk);
            end
        end
        mem_ready_i = 1'b0;
        start_i = 1'b0;
        if (!finished) chk(0, "R9", "operation never finished", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 0 && mem_req_o == 0 && rf_we_o == 0 && flush_o == 0, "R9", "reset quiet",
            {28'd0, done_o, mem_req_o, rf_we_o, flush_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R3 R4 R7: single and full masks in every mode
        for (int m = 0; m < 8; m++) begin
            run_op(16'h0001, 32'h0000_1000, 4'd13, m[0], m[1], m[2], 1'b1, 1'b0, 32'h0000_0800, 0, 0);
            run_op(16'h8000, 32'h0000_2000, 4'd13, m[0], m[1], m[2], 1'b1, 1'b0, 32'h0000_0804, 1, 0);
            run_op(16'hFFFF, 32'h0000_3000, 4'd2,  m[0], m[1], m[2], 1'b1, 1'b0, 32'h0000_0808, 2, 0);
        end
        // R4 wrap at both ends of the address space
        run_op(16'h00F0, 32'h0000_0008, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h100, 0, 0);
        run_op(16'h0F00, 32'hFFFF_FFF8, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h104, 1, 0);
        // R10 base in list: load cancels, store keeps
        run_op(16'h0030, 32'h0000_4000, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h200, 0, 0);
        run_op(16'h0030, 32'h0000_4000, 4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h200, 0, 0);
        run_op(16'h0030, 32'h0000_4000, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h200, 0, 0);
        // R11 empty list
        run_op(16'h0000, 32'h0000_5000, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h300, 0, 0);
        run_op(16'h0000, 32'h0000_5000, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h300, 0, 0);
        // R12 user bank refused
        run_op(16'hA5C3, 32'h0000_6000, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h400, 0, 0);
        run_op(16'h8001, 32'h0000_6000, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h400, 0, 0);
        // R13 start held high with scrambled operands while busy
        run_op(16'hA5C3, 32'h0000_7000, 4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h500, 1, 1);
        run_op(16'h8421, 32'h0000_7000, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h500, 2, 1);
        // R8 sweep: near-exhaustive masks over the high and low groups, all modes
        for (int i = 0; i < 64; i++) begin
            for (int m = 0; m < 8; m++) begin
                run_op({i[5:3], 5'b0, i[2:0], 5'b0}, 32'h0001_0000 + 32'(i * 64), 4'(i),
                       m[0], m[1], m[2], i[0], 1'b0, 32'h0000_0A00 + 32'(i * 4), i % 3, 0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule